// File: doc/BRIEF.md
# Serial Byte Receiver with Held-Back Overrun Status

This block takes an asynchronous serial line carrying 8-bit words and presents each received word to a processor through two read-only registers: a one-byte data holding register and a status byte. The line is oversampled sixteen times per bit. The oversample tick comes from a fixed clock divider. A configuration pin selects whether frames carry one or two stop bits. A single interrupt output tells software that a byte has arrived badly or that data was lost.

When a byte arrives while the holding register still has an unread byte, the new byte is dropped and the stored byte is kept. The loss is not shown at once. The status first looks normal, and the overrun appears only after software has taken the good byte out with a data read. At that point the stored byte stays marked as present but must be treated as unreliable. A second data read clears the error. The break flag is reported beside the overrun and tells whether the lost frame was a break on the line.

Top module: `serial_rx_held`

## Requirements
- R1: A frame that completes while the holding register has an unread byte never replaces that byte; the next data read returns the byte stored first.
- R2: While a lost frame is pending, status bit 4 (overrun) and bit 3 (break) read 0. The data read that returns the good byte makes bit 4 read 1, and bit 7 (byte present) stays 1.
- R3: A break is a frame whose eight data bits are all 0 and whose first stop bit samples 0. Status bit 3 is set if the frame that caused an overrun was a break. It is also set together with the byte when a break is stored into an empty register.
- R4: A data read made while an overrun is shown clears status bits 7, 4, 3 and 1 and drops the interrupt, unless another lost frame is waiting.
- R5: The holding register changes only when a frame completes. It never changes on a register read.
- R6: Status bit 1 (framing) is set with the stored byte when the first stop bit samples 0. With `two_stop` high, the second stop bit is never checked.
- R7: A framing error raises `irq` as soon as the stop bit is sampled, whether or not the frame is stored. Any data read clears the framing interrupt.
- R8: An overrun raises `irq` at the data read that reveals it. If the shown byte is already marked unreliable, a further lost frame is reported at once and `irq` stays high. A plain data read clears it.
- R9: A start bit is accepted only if the line is still 0 at oversample count 8. A shorter low pulse is ignored and receives nothing.
- R10: The line passes two synchronizing flops. Bits are sampled at the middle of each bit time, least significant bit first, after a start bit of 0.
- R11: Reading the status register (`rd_sel` = 0) changes neither the status, the data, nor `irq`.
- R12: After a stop bit that samples 0, the receiver waits for the line to return to 1 before it looks for a new start bit. A held-low line gives exactly one frame.
- R13: After reset the status reads 0x00 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| two_stop | input | 1 | 1 selects two stop bits per frame |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_sel | input | 1 | 0 selects status, 1 selects the holding register |
| rd_data | output | 8 | Selected register value, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt, high while a framing or overrun event is unserviced |

## Verification
The bench sends two frames in a row without reading and checks that the first byte survives and that the overrun stays hidden until the first data read. A design that overwrote the register, or showed the error early, would return the second byte or raise bit 4 too soon. It sends a lost break frame and checks the break bit and the second-read clear; a design that cleared on the first read would drop bit 7 too early. It also repeats status reads, which a design with read side effects would disturb. Finally it covers a short false start, a line held low past a break, and a zero second stop bit in two-stop mode. A design that did these wrong would produce a spurious byte, several break frames, or a false framing flag.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int HALF   = OSR / 2;
    localparam int CNT_W  = $clog2(OSR);
    localparam int BIT_W  = $clog2(DATA_W);

    localparam int ST_FULL = 7;
    localparam int ST_OVR  = 4;
    localparam int ST_BRK  = 3;
    localparam int ST_FE   = 1;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP1,
        RX_STOP2,
        RX_WAIT_HI
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              stop_ok;
        logic              is_break;
    } frame_t;

    typedef struct packed {
        logic full;
        logic ovr;
        logic brk;
        logic fe;
    } stat_t;

    function automatic logic [7:0] pack_status(stat_t s);
        logic [7:0] r;
        r          = '0;
        r[ST_FULL] = s.full;
        r[ST_OVR]  = s.ovr;
        r[ST_BRK]  = s.brk;
        r[ST_FE]   = s.fe;
        return r;
    endfunction

endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [DW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == DW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = (cnt == DW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_core.sv
module srx_core
    import srx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rx,
    input  logic   two_stop,
    output logic   done,
    output frame_t frame
);
    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;

    logic at_mid;
    logic at_full;

    assign at_mid  = tick && (cnt == CNT_W'(HALF - 1));
    assign at_full = tick && (cnt == CNT_W'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sh    <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    if (tick && !rx) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (at_mid) begin
                        cnt <= '0;
                        if (rx) begin
                            st <= RX_IDLE;
                        end else begin
                            st   <= RX_DATA;
                            bidx <= '0;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (at_full) begin
                        cnt <= '0;
                        sh  <= {rx, sh[DATA_W-1:1]};
                        if (bidx == BIT_W'(DATA_W - 1)) begin
                            st <= RX_STOP1;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP1: begin
                    if (at_full) begin
                        cnt            <= '0;
                        done           <= 1'b1;
                        frame.data     <= sh;
                        frame.stop_ok  <= rx;
                        frame.is_break <= (sh == '0) && !rx;
                        if (!rx) begin
                            st <= RX_WAIT_HI;
                        end else if (two_stop) begin
                            st <= RX_STOP2;
                        end else begin
                            st <= RX_IDLE;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP2: begin
                    if (at_full) begin
                        cnt <= '0;
                        st  <= RX_WAIT_HI;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_WAIT_HI: begin
                    if (rx) begin
                        st <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    AST_DONE_SPACED: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("completion pulse repeated"); // R10

    AST_START_HAS_LOW_LINE: assert property (@(posedge clk) disable iff (rst)
        (st == RX_IDLE && tick && rx) |=> (st == RX_IDLE)) else $error("start on high line"); // R9

endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  frame_t            frame,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [DATA_W-1:0] data_q, data_n;
    stat_t             st_q, st_n;
    logic              pend_ovr_q, pend_ovr_n;
    logic              pend_brk_q, pend_brk_n;
    logic              irq_fe_q, irq_fe_n;
    logic              irq_ovr_q, irq_ovr_n;
    logic              data_rd;
    logic [7:0]        status_w;

    assign data_rd  = rd_en && rd_sel;
    assign status_w = pack_status(st_q);

    // A read in the same cycle as a frame completion is applied first.
    always_comb begin
        data_n     = data_q;
        st_n       = st_q;
        pend_ovr_n = pend_ovr_q;
        pend_brk_n = pend_brk_q;
        irq_fe_n   = irq_fe_q;
        irq_ovr_n  = irq_ovr_q;

        if (data_rd) begin
            irq_fe_n = 1'b0;
            if (pend_ovr_q) begin
                st_n.ovr   = 1'b1;
                st_n.brk   = pend_brk_q;
                st_n.fe    = 1'b0;
                pend_ovr_n = 1'b0;
                pend_brk_n = 1'b0;
                irq_ovr_n  = 1'b1;
            end else begin
                st_n      = '0;
                irq_ovr_n = 1'b0;
            end
        end

        if (done) begin
            if (!frame.stop_ok) begin
                irq_fe_n = 1'b1;
            end
            if (!st_n.full) begin
                data_n    = frame.data;
                st_n.full = 1'b1;
                st_n.fe   = !frame.stop_ok;
                st_n.brk  = frame.is_break;
            end else if (st_n.ovr) begin
                st_n.brk = st_n.brk | frame.is_break;
            end else begin
                pend_ovr_n = 1'b1;
                pend_brk_n = pend_brk_n | frame.is_break;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q     <= '0;
            st_q       <= '0;
            pend_ovr_q <= 1'b0;
            pend_brk_q <= 1'b0;
            irq_fe_q   <= 1'b0;
            irq_ovr_q  <= 1'b0;
        end else begin
            data_q     <= data_n;
            st_q       <= st_n;
            pend_ovr_q <= pend_ovr_n;
            pend_brk_q <= pend_brk_n;
            irq_fe_q   <= irq_fe_n;
            irq_ovr_q  <= irq_ovr_n;
        end
    end

    assign rd_data = rd_sel ? data_q : status_w;
    assign irq     = irq_fe_q | irq_ovr_q;

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (done && st_q.full && !data_rd) |=> $stable(data_q)) else $error("unread byte replaced"); // R1

    AST_REVEAL_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (data_rd && pend_ovr_q) |=> (status_w[ST_OVR] && status_w[ST_FULL] && irq)) else $error("overrun not revealed"); // R2

    AST_DATA_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(data_q)) else $error("data changed without frame"); // R5

    AST_FE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (done && !frame.stop_ok) |=> irq) else $error("framing irq missing"); // R7

    AST_STATUS_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_sel && !done) |=> ($stable(status_w) && $stable(irq))) else $error("status read side effect"); // R11

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !pend_ovr_q && !done) |=> (!status_w[ST_FULL] && !irq)) else $error("read did not clear"); // R4

endmodule

// File: rtl/serial_rx_held.sv
module serial_rx_held
    import srx_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       two_stop,
    input  logic       rd_en,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       irq
);
    logic   tick;
    logic   rx_s;
    logic   done;
    frame_t frame;

    srx_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    srx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    srx_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rx       (rx_s),
        .two_stop (two_stop),
        .done     (done),
        .frame    (frame)
    );

    srx_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .frame   (frame),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: tb/tb_serial_rx_held.sv
module tb_serial_rx_held;
    localparam int BITCLK = 64;
    localparam int WD     = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       two_stop = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;
    bit cmp_en = 0;

    // behavioural reference state
    bit [7:0] m_data;
    bit m_full, m_ovr, m_brk, m_fe;
    bit m_pend_ovr, m_pend_brk, m_irq_fe, m_irq_ovr;

    serial_rx_held dut (
        .clk(clk), .rst(rst), .rxd(rxd), .two_stop(two_stop),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic bit [7:0] m_status();
        return {m_full, 2'b00, m_ovr, m_brk, 1'b0, m_fe, 1'b0};
    endfunction

    function automatic bit m_irq();
        return m_irq_fe | m_irq_ovr;
    endfunction

    function automatic void model_reset();
        m_data = 0; m_full = 0; m_ovr = 0; m_brk = 0; m_fe = 0;
        m_pend_ovr = 0; m_pend_brk = 0; m_irq_fe = 0; m_irq_ovr = 0;
    endfunction

    function automatic void model_frame(bit [7:0] b, bit stop_ok);
        bit is_brk;
        is_brk = (b == 8'h00) && !stop_ok;
        if (!stop_ok) m_irq_fe = 1;
        if (!m_full) begin
            m_data = b; m_full = 1; m_fe = !stop_ok; m_brk = is_brk;
        end else if (m_ovr) begin
            m_brk = m_brk | is_brk;
        end else begin
            m_pend_ovr = 1; m_pend_brk = m_pend_brk | is_brk;
        end
    endfunction

    function automatic void model_data_read();
        m_irq_fe = 0;
        if (m_pend_ovr) begin
            m_ovr = 1; m_brk = m_pend_brk; m_fe = 0;
            m_pend_ovr = 0; m_pend_brk = 0; m_irq_ovr = 1;
        end else begin
            m_full = 0; m_ovr = 0; m_brk = 0; m_fe = 0; m_irq_ovr = 0;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference while the line is quiet
    always @(negedge clk) begin
        #2;
        if (cmp_en && !finished) begin
            chk(rd_data == m_status(), "R11 status vs model", rd_data, m_status());
            chk(irq == m_irq(), "R7/R8 irq vs model", irq, m_irq());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD && !finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog got=%0d exp=%0d", cyc, WD);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic hold(input bit v, input int n);
        @(negedge clk);
        rxd = v;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic send(input bit [7:0] b, input bit s1, input bit s2, input int extra_low);
        cmp_en = 0;
        hold(1'b0, BITCLK);
        for (int i = 0; i < 8; i++) hold(b[i], BITCLK);
        hold(s1, BITCLK);
        if (two_stop) hold(s2, BITCLK);
        if (extra_low > 0) hold(1'b0, extra_low * BITCLK);
        hold(1'b1, 2 * BITCLK);
        model_frame(b, s1);
        cmp_en = 1;
    endtask

    task automatic rd(input bit sel, input string req);
        bit [7:0] got, exp;
        cmp_en = 0;
        @(negedge clk);
        rd_en = 1; rd_sel = sel;
        #1;
        got = rd_data;
        exp = sel ? m_data : m_status();
        chk(got == exp, req, got, exp);
        @(posedge clk);
        if (sel) model_data_read();
        @(negedge clk);
        rd_en = 0; rd_sel = 0;
        cmp_en = 1;
    endtask

    task automatic expect_status(input bit [7:0] exp, input bit exp_irq, input string req);
        @(negedge clk);
        #1;
        chk(rd_data == exp, req, rd_data, exp);
        chk(irq == exp_irq, req, irq, exp_irq);
    endtask

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;
        expect_status(8'h00, 1'b0, "R13 reset state");
        cmp_en = 1;

        // plain byte, LSB first
        send(8'h5A, 1, 1, 0);
        expect_status(8'h80, 1'b0, "R10 byte present");
        rd(1, "R10 data 5A");
        expect_status(8'h00, 1'b0, "R4 cleared after read");

        // overrun with hidden status
        send(8'hA5, 1, 1, 0);
        send(8'h3C, 1, 1, 0);
        expect_status(8'h80, 1'b0, "R2 overrun hidden");
        rd(1, "R1 first byte kept");
        expect_status(8'h90, 1'b1, "R2 R8 overrun revealed");
        rd(0, "R11 status read 1");
        rd(0, "R11 status read 2");
        rd(1, "R5 unreliable byte unchanged");
        expect_status(8'h00, 1'b0, "R4 second read clears");

        // lost break frame, then immediate overrun while flagged
        send(8'h11, 1, 1, 0);
        send(8'h00, 0, 1, 0);
        expect_status(8'h80, 1'b1, "R7 fe irq at once on lost break");
        rd(1, "R1 byte 11 kept");
        expect_status(8'h98, 1'b1, "R3 break beside overrun");
        send(8'h77, 1, 1, 0);
        expect_status(8'h98, 1'b1, "R8 immediate overrun");
        rd(1, "R5 data still 11");
        expect_status(8'h00, 1'b0, "R4 clear after break overrun");

        // framing error into empty register
        send(8'h81, 0, 1, 0);
        expect_status(8'h82, 1'b1, "R6 framing flag");
        rd(1, "R7 framing byte read");
        expect_status(8'h00, 1'b0, "R7 fe irq cleared");

        // false start
        cmp_en = 0;
        hold(1'b0, 12);
        hold(1'b1, 3 * BITCLK);
        cmp_en = 1;
        expect_status(8'h00, 1'b0, "R9 false start ignored");
        send(8'hC3, 1, 1, 0);
        rd(1, "R9 receiver recovers C3");

        // break into empty register, line held low afterward
        send(8'h00, 0, 1, 3);
        expect_status(8'h8A, 1'b1, "R3 R12 single break frame");
        rd(1, "R12 break data 00");
        expect_status(8'h00, 1'b0, "R12 no extra frame");

        // two stop bits
        two_stop = 1;
        send(8'h96, 1, 0, 0);
        expect_status(8'h80, 1'b0, "R6 second stop unchecked");
        rd(1, "R6 data 96");
        send(8'h69, 0, 1, 0);
        expect_status(8'h82, 1'b1, "R6 first stop checked in two-stop");
        rd(1, "R7 data 69");
        expect_status(8'h00, 1'b0, "R4 final clear");

        cmp_en = 0;
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule